// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves a parallel word between two ports, A and B, in either direction. Each direction has its own storage word and its own three controls: an output enable, a latch enable and a port clock. Each path runs in one of three modes. In transparent mode the latch enable is high and the far port follows the near port. In clocked mode the latch enable is low and a rising port clock captures the near port. In latched mode the latch enable is low and the port clock is steady, so the stored word is held. The A-to-B output enable is active high and the B-to-A output enable is active low.

The level-sensitive latch and the port-clock flip-flop are folded into one register per direction, clocked by a fast system clock. The latch enable acts as a synchronous load. The port clock is edge-detected against its value on the previous system clock cycle. For each port the block exposes an internal data/enable pair for fabric use, and it builds the tri-state pin drivers only at the top level.

Each direction is a small state machine with three states. `LANE_ARM` is entered at reset and lasts one cycle; it records the port clock level. `LANE_FOLLOW` is active while the latch enable is high. `LANE_HOLD` is active while the latch enable is low. The transitions are: arm-to-follow and arm-to-hold, chosen by the latch enable on the first cycle after reset; follow-to-hold when the latch enable falls; hold-to-follow when it rises. A port-clock rise seen in `LANE_HOLD` stays in `LANE_HOLD` and performs a capture load.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While `ab_le` is 1, `b_drive_data` equals the current `port_a` value in the same cycle, whatever `ab_clk` does.
- R2: While `ab_le` is 0, a rise of `ab_clk` (high at a system clock edge after being low at the previous edge) loads `port_a` at that edge, and `b_drive_data` shows the loaded word from then on.
- R3: While `ab_le` is 0 and `ab_clk` stays high, stays low or falls, `b_drive_data` does not change, even if `port_a` changes.
- R4: When `ab_le` goes from 1 to 0 with `ab_clk` already high, `b_drive_data` holds the `port_a` value sampled at the last system clock edge at which `ab_le` was 1.
- R5: `b_drive_en` equals `ab_oe` (active high), and `port_b` is left undriven when `ab_oe` is 0.
- R6: `a_drive_en` equals the inverse of `ba_oe_n` (active low). The B-to-A path applies R1 to R4 with `ba_le`, `ba_clk` and `port_b` to produce `a_drive_data`, independently of the A-to-B path.
- R7: After reset both stored words are 0. The first system clock edge after reset only records the port clock level, so a port clock that is already high at reset release causes no capture.
- R8: Every bit position of the `WIDTH`-bit path behaves identically, including the all-ones and alternating patterns.
- R9: When `ab_oe` equals `ba_oe_n` (one direction selected), exactly one of `a_drive_en` and `b_drive_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all controls |
| rst_n | input | 1 | Active-low asynchronous reset |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable |
| ab_clk | input | 1 | A-to-B port clock, rise-detected |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_clk | input | 1 | B-to-A port clock, rise-detected |
| port_a | inout | WIDTH | A-side pins |
| port_b | inout | WIDTH | B-side pins |
| a_drive_data | output | WIDTH | Word the block presents to side A |
| a_drive_en | output | 1 | Side A driver enable |
| b_drive_data | output | WIDTH | Word the block presents to side B |
| b_drive_en | output | 1 | Side B driver enable |

## Verification
The bench builds the block with the default `WIDTH` of 18. This makes the all-ones, alternating and single-pattern words cover every bit lane, so a fault confined to the top bit or to the odd bits changes a compared word. The vector walk runs the A-to-B path through transparent, falling-enable, steady-clock, falling-clock and rising-clock steps in sequence. Directed steps then drive the B-to-A path from the B pins, confirm that the A-to-B stored word is unaffected, sweep the four enable combinations for driver exclusivity, and release reset with the port clock already high.

// File: rtl/bidir_xcvr_pkg.sv
package bidir_xcvr_pkg;

    // Per-direction mode tracking
    typedef enum logic [1:0] {
        LANE_ARM    = 2'd0,
        LANE_FOLLOW = 2'd1,
        LANE_HOLD   = 2'd2
    } lane_state_t;

    // Control pair steering one direction
    typedef struct packed {
        logic le;
        logic pclk;
    } lane_ctl_t;

endpackage

// File: rtl/bidir_xcvr_edge.sv
module bidir_xcvr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk,
    output logic rise_raw
);

    logic pclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pclk_prev_q <= 1'b0;
        end else begin
            pclk_prev_q <= pclk;
        end
    end

    // Unqualified: the lane masks this during its arming cycle
    assign rise_raw = pclk & ~pclk_prev_q;

endmodule

// File: rtl/bidir_xcvr_lane.sv
module bidir_xcvr_lane
    import bidir_xcvr_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lane_ctl_t        ctl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    lane_state_t      state_q;
    lane_state_t      state_d;
    logic [WIDTH-1:0] stored_q;
    logic [WIDTH-1:0] stored_d;
    logic             rise_raw;
    logic             load;
    logic             capture;

    bidir_xcvr_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pclk     (ctl.pclk),
        .rise_raw (rise_raw)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LANE_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_ARM:    state_d = ctl.le ? LANE_FOLLOW : LANE_HOLD;
            LANE_FOLLOW: state_d = ctl.le ? LANE_FOLLOW : LANE_HOLD;
            LANE_HOLD:   state_d = ctl.le ? LANE_FOLLOW : LANE_HOLD;
            default:     state_d = LANE_ARM;
        endcase
    end

    // Output and load decode
    always_comb begin
        capture  = 1'b0;
        load     = 1'b0;
        dout     = stored_q;
        unique case (state_q)
            LANE_ARM: begin
                capture = 1'b0;
            end
            LANE_FOLLOW, LANE_HOLD: begin
                capture = rise_raw & ~ctl.le;
            end
            default: begin
                capture = 1'b0;
            end
        endcase
        if (ctl.le) begin
            dout = din;
            load = 1'b1;
        end else if (capture) begin
            load = 1'b1;
        end
        stored_d = load ? din : stored_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q <= '0;
        end else begin
            stored_q <= stored_d;
        end
    end

    // R2: a capture shows the sampled word on the next cycle
    a_r2_capture_shows: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (ctl.le || dout == $past(din)));

    // R3: with no capture and the enable low, the output stays put
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.le && !capture) |=> (ctl.le || $stable(dout)));

    // R7: the arming cycle presents the cleared word
    a_r7_arm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_ARM && !ctl.le) |-> (dout == '0));

endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
    import bidir_xcvr_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ab_oe,
    input  logic             ab_le,
    input  logic             ab_clk,
    input  logic             ba_oe_n,
    input  logic             ba_le,
    input  logic             ba_clk,
    inout  wire  [WIDTH-1:0] port_a,
    inout  wire  [WIDTH-1:0] port_b,
    output logic [WIDTH-1:0] a_drive_data,
    output logic             a_drive_en,
    output logic [WIDTH-1:0] b_drive_data,
    output logic             b_drive_en
);

    lane_ctl_t ab_ctl;
    lane_ctl_t ba_ctl;

    assign ab_ctl = '{le: ab_le, pclk: ab_clk};
    assign ba_ctl = '{le: ba_le, pclk: ba_clk};

    bidir_xcvr_lane #(.WIDTH(WIDTH)) u_lane_ab (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ab_ctl),
        .din   (port_a),
        .dout  (b_drive_data)
    );

    bidir_xcvr_lane #(.WIDTH(WIDTH)) u_lane_ba (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ba_ctl),
        .din   (port_b),
        .dout  (a_drive_data)
    );

    // Opposite enable polarities per direction
    assign b_drive_en = ab_oe;
    assign a_drive_en = ~ba_oe_n;

    // Pin drivers live only here
    assign port_b = b_drive_en ? b_drive_data : {WIDTH{1'bz}};
    assign port_a = a_drive_en ? a_drive_data : {WIDTH{1'bz}};

    // R1: transparent A-to-B path tracks the A pins
    a_r1_ab_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_le && !a_drive_en) |-> (b_drive_data == port_a));

    // R6: transparent B-to-A path tracks the B pins
    a_r6_ba_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_le && !b_drive_en) |-> (a_drive_data == port_b));

    // R9: one selected direction means one active driver
    a_r9_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_oe == ba_oe_n) |-> (a_drive_en ^ b_drive_en));

endmodule

// File: tb/test_bidir_latch_xcvr.sv
module test_bidir_latch_xcvr;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ab_oe = 1'b0;
    logic         ab_le = 1'b0;
    logic         ab_clk = 1'b0;
    logic         ba_oe_n = 1'b1;
    logic         ba_le = 1'b0;
    logic         ba_clk = 1'b0;
    logic [W-1:0] tb_a = '0;
    logic         tb_a_en = 1'b0;
    logic [W-1:0] tb_b = '0;
    logic         tb_b_en = 1'b0;
    wire  [W-1:0] port_a;
    wire  [W-1:0] port_b;
    logic [W-1:0] a_drive_data;
    logic         a_drive_en;
    logic [W-1:0] b_drive_data;
    logic         b_drive_en;

    int applied = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // Bench-side pin drivers model the remote parts
    assign port_a = tb_a_en ? tb_a : {W{1'bz}};
    assign port_b = tb_b_en ? tb_b : {W{1'bz}};

    always #2 clk = ~clk;

    bidir_latch_xcvr #(.WIDTH(W)) i_bidir_latch_xcvr (
        .clk          (clk),
        .rst_n        (rst_n),
        .ab_oe        (ab_oe),
        .ab_le        (ab_le),
        .ab_clk       (ab_clk),
        .ba_oe_n      (ba_oe_n),
        .ba_le        (ba_le),
        .ba_clk       (ba_clk),
        .port_a       (port_a),
        .port_b       (port_b),
        .a_drive_data (a_drive_data),
        .a_drive_en   (a_drive_en),
        .b_drive_data (b_drive_data),
        .b_drive_en   (b_drive_en)
    );

    // {le, pclk, A word, expected B word}, one system clock per row
    typedef logic [2*W+1:0] vec_t;
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        {1'b0, 1'b0, 18'h3A5A5, 18'h00000},  // R7 cleared, R3 hold
        {1'b1, 1'b0, 18'h15555, 18'h15555},  // R1 transparent, R8
        {1'b1, 1'b1, 18'h2AAAA, 18'h2AAAA},  // R1 clock ignored
        {1'b0, 1'b1, 18'h2AAAA, 18'h2AAAA},  // R4 enable falls, clock high
        {1'b0, 1'b1, 18'h0F0F0, 18'h2AAAA},  // R3 clock steady high
        {1'b0, 1'b0, 18'h0F0F0, 18'h2AAAA},  // R3 clock falls
        {1'b0, 1'b1, 18'h0F0F0, 18'h0F0F0},  // R2 rise captures
        {1'b0, 1'b1, 18'h3FFFF, 18'h0F0F0},  // R3 steady high
        {1'b0, 1'b0, 18'h3FFFF, 18'h0F0F0},  // R3 steady low
        {1'b0, 1'b1, 18'h3FFFF, 18'h3FFFF},  // R2 capture, R8 all ones
        {1'b0, 1'b0, 18'h00000, 18'h3FFFF},  // R3 hold
        {1'b1, 1'b0, 18'h12345, 18'h12345}   // R1 back to transparent
    };

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        // Reset state: A-to-B selected, A pins driven by the bench
        ab_oe = 1'b1;
        tb_a_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R7 reset word", b_drive_data, '0);
        check("R5 b enable on", {17'b0, b_drive_en}, 18'd1);
        check("R6 a enable off", {17'b0, a_drive_en}, 18'd0);

        // Vector walk on the A-to-B path
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ab_le  = VECS[i][2*W+1];
            ab_clk = VECS[i][2*W];
            tb_a   = VECS[i][2*W-1:W];
            step();
            check($sformatf("R1-R4 row %0d", i), b_drive_data, VECS[i][W-1:0]);
        end

        // Park A-to-B in hold with a known word
        @(negedge clk);
        ab_le = 1'b0;
        ab_clk = 1'b0;
        tb_a = 18'h0AAAA;
        step();
        check("R3 park", b_drive_data, 18'h12345);

        // Switch to B-to-A: remove A-side drivers, bench drives B
        @(negedge clk);
        ab_oe = 1'b0;
        tb_a_en = 1'b0;
        tb_b_en = 1'b1;
        tb_b = 18'h2C3C3;
        ba_oe_n = 1'b0;
        ba_le = 1'b1;
        #1;
        check("R5 b enable off", {17'b0, b_drive_en}, 18'd0);
        check("R6 a enable on", {17'b0, a_drive_en}, 18'd1);
        check("R6 BA transparent", a_drive_data, 18'h2C3C3);
        check("R6 BA pins", port_a, 18'h2C3C3);
        step();
        @(negedge clk);
        ba_le = 1'b0;
        tb_b = 18'h11111;
        step();
        check("R6 BA hold", a_drive_data, 18'h2C3C3);
        @(negedge clk);
        ba_clk = 1'b1;
        step();
        check("R6 BA capture", a_drive_data, 18'h11111);
        @(negedge clk);
        tb_b = 18'h3F00F;
        step();
        check("R6 BA clock high hold", a_drive_data, 18'h11111);

        // A-to-B word untouched by B-to-A activity
        @(negedge clk);
        ba_oe_n = 1'b1;
        tb_b_en = 1'b0;
        ab_oe = 1'b1;
        #1;
        check("R6 AB independent", b_drive_data, 18'h12345);
        check("R5 B pins driven", port_b, 18'h12345);

        // Driver exclusivity across enable combinations
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ab_oe = k[0];
            ba_oe_n = k[1];
            #1;
            check($sformatf("R9 enables %0d", k), {16'b0, a_drive_en, b_drive_en},
                  {16'b0, ~k[1], k[0]});
        end
        @(negedge clk);
        ab_oe = 1'b1;
        ba_oe_n = 1'b1;

        // Reset with port clock already high: no capture on release
        tb_a_en = 1'b1;
        tb_a = 18'h35353;
        ab_le = 1'b0;
        ab_clk = 1'b1;
        rst_n = 1'b0;
        #1;
        check("R7 cleared in reset", b_drive_data, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        step();
        check("R7 no capture after release", b_drive_data, '0);
        @(negedge clk);
        ab_clk = 1'b0;
        step();
        @(negedge clk);
        ab_clk = 1'b1;
        step();
        check("R2 first real rise", b_drive_data, 18'h35353);

        finish_run();
    end

endmodule